// File: doc/BRIEF.md
# Platform-Level Interrupt Controller

This block collects level-sensitive interrupt requests from a configurable number of external sources and routes them to a small set of hart contexts. Even-numbered contexts serve machine mode of hart c/2, and odd-numbered contexts serve supervisor mode of that hart. Each source has a programmable priority. Each context has its own enable mask, its own priority threshold and its own claim/complete register. A context's interrupt line is high while at least one source is pending, enabled for that context and above the context's threshold.

Software reaches the block through a simple 32-bit register port. A request is a valid strobe, a write flag, a byte address and write data, and read data appears on the following cycle. The handler reads the claim register to get the winning source ID, and that read also clears the source's pending bit. When the work is done, the handler writes the same ID back to finish the request. Between claim and completion the source stays blocked, so a level input that is still held cannot raise a second request.

Top module: `ext_irq_ctrl`

## Requirements
- R1: The priority of source s (1..NUM_SRC) is the register at byte offset 4*s. It keeps PRIO_W bits, and read-back zero-fills the upper bits. Offset 0 is reserved for source 0: writes to it are dropped and it reads zero.
- R2: A source whose priority is 0 never raises a context interrupt, and a claim never returns it.
- R3: The enable bits for context c are at offset 0x2000 + 0x80*c + 4*(s/32), bit s%32, one bit per source. Bits that map to ID 0 or to IDs above NUM_SRC read zero.
- R4: The threshold of context c is at offset 0x200000 + 0x1000*c. A pending, enabled source qualifies only when its priority is strictly greater than the threshold.
- R5: A read of the claim register at offset 0x200000 + 0x1000*c + 4 returns the qualifying source with the highest priority. When priorities are equal, the lower ID wins. The read returns 0 when nothing qualifies.
- R6: A claim read clears the pending bit of the returned source. The source then stays blocked until it is completed, so a held level input raises nothing, and the context line drops if no other source qualifies.
- R7: Writing a source ID to any context's claim register completes that source. If its level input is still high, it becomes pending again two cycles after the write.
- R8: A completion write is ignored when the ID is 0, when the ID is above NUM_SRC, or when the source is not in flight.
- R9: Enables and thresholds are separate for each context. A source qualifies for a context only through that context's own enable bit and threshold.
- R10: Read data is valid on the cycle after the request. Reads of unmapped or misaligned offsets return zero.
- R11: After reset, every interrupt output is low and all priorities, enables and thresholds read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_irq_i | input | NUM_SRC | Level requests; bit k belongs to source ID k+1 |
| req_valid_i | input | 1 | Register access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address of the access |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | NUM_CTX | Interrupt line of each context |

## Verification
The bench targets the threshold comparison at equality. A design that compares with greater-or-equal would raise the line when priority and threshold match. It also gives two sources the same priority. A design that scans in the wrong direction, or replaces the winner on equal priority, would hand out the higher ID first.

The bench holds level inputs high across a claim and feeds completions with a bad ID or for a source that is not in flight. A design that lets the level input re-arm the gateway too early would raise the line again at once, and one that accepts any completion would unblock a source that was never claimed. The bench also completes a source through a different context's register and checks the enable padding bits and the last source ID. Errors there show up as a missing re-arm, as phantom enable bits, or as a lost top priority register.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_ENABLE,
    RK_THRESH,
    RK_CLAIM
  } reg_kind_e;

  // Region bases and strides, expressed in 32-bit word addresses
  localparam logic [31:0] ENABLE_BASE_W   = 32'h0000_0800;
  localparam logic [31:0] ENABLE_STRIDE_W = 32'h0000_0020;
  localparam logic [31:0] CTX_BASE_W      = 32'h0008_0000;

endpackage

// File: rtl/ext_irq_decode.sv
module ext_irq_decode
  import ext_irq_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int NUM_SRC  = 53,
  parameter int NUM_CTX  = 2,
  parameter int EN_WORDS = 2,
  parameter int SRC_W    = 6,
  parameter int CTX_W    = 1,
  parameter int EW_W     = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic [EW_W-1:0]   word_o
);

  localparam logic [31:0] EN_SPAN = ENABLE_STRIDE_W * 32'(NUM_CTX);

  logic [31:0] waddr;
  logic [31:0] en_rel;
  logic [31:0] ctx_rel;

  always_comb begin
    waddr   = 32'(addr_i[ADDR_W-1:2]);
    en_rel  = waddr - ENABLE_BASE_W;
    ctx_rel = waddr - CTX_BASE_W;
    kind_o  = RK_NONE;
    src_o   = '0;
    ctx_o   = '0;
    word_o  = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (waddr >= 32'd1 && waddr <= 32'(NUM_SRC)) begin
        kind_o = RK_PRIO;
        src_o  = waddr[SRC_W-1:0];
      end else if (waddr >= ENABLE_BASE_W && en_rel < EN_SPAN) begin
        if ({27'd0, en_rel[4:0]} < 32'(EN_WORDS)) begin
          kind_o = RK_ENABLE;
          ctx_o  = CTX_W'(en_rel >> 5);
          word_o = en_rel[EW_W-1:0];
        end
      end else if (waddr >= CTX_BASE_W && (ctx_rel >> 10) < 32'(NUM_CTX) &&
                   ctx_rel[9:1] == 9'd0) begin
        kind_o = ctx_rel[0] ? RK_CLAIM : RK_THRESH;
        ctx_o  = CTX_W'(ctx_rel >> 10);
      end
    end
  end

endmodule

// File: rtl/ext_irq_gateway.sv
module ext_irq_gateway (
  input  logic clk,
  input  logic rst_ni,
  input  logic level_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o
);

  logic pend_q, pend_n;
  logic infl_q, infl_n;
  logic gw_en;

  assign gw_en = level_i | claim_i | complete_i;

  always_comb begin
    pend_n = pend_q;
    infl_n = infl_q;
    if (claim_i && pend_q) begin
      pend_n = 1'b0;
      infl_n = 1'b1;
    end else if (complete_i && infl_q) begin
      infl_n = 1'b0;
    end else if (level_i && !pend_q && !infl_q) begin
      pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      infl_q <= 1'b0;
    end else if (gw_en) begin
      pend_q <= pend_n;
      infl_q <= infl_n;
    end
  end

  assign pending_o = pend_q;

  // R6: a source in flight never holds a fresh request
  assert_blocked_while_inflight_R6: assert property (
    @(posedge clk) disable iff (!rst_ni) infl_q |-> !pend_q)
    else $error("pending while in flight");

  // R6: a claim of a pending source moves it to in flight
  assert_claim_moves_R6: assert property (
    @(posedge clk) disable iff (!rst_ni) (claim_i && pend_q) |=> (infl_q && !pend_q))
    else $error("claim did not take effect");

  // R8: completing an idle source leaves it idle
  assert_idle_complete_ignored_R8: assert property (
    @(posedge clk) disable iff (!rst_ni) (complete_i && !infl_q && !claim_i) |=> !infl_q)
    else $error("stray completion changed state");

  // R7: completion with level held re-arms two cycles later
  assert_rearm_R7: assert property (
    @(posedge clk) disable iff (!rst_ni) (complete_i && infl_q && level_i) |-> ##2 pend_q)
    else $error("no re-arm after completion");

endmodule

// File: rtl/ext_irq_target.sv
module ext_irq_target #(
  parameter int NUM_SRC = 53,
  parameter int PRIO_W  = 3,
  parameter int SRC_W   = 6
) (
  input  logic [NUM_SRC:1]             pending_i,
  input  logic [NUM_SRC:1]             enable_i,
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]            thresh_i,
  output logic [SRC_W-1:0]             best_id_o,
  output logic                         irq_o
);

  logic [PRIO_W-1:0] best_p;

  // Ascending scan with strict compare: equal priority keeps the lower ID
  always_comb begin
    best_p    = '0;
    best_id_o = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      if (pending_i[s] && enable_i[s] && prio_i[s] > thresh_i && prio_i[s] > best_p) begin
        best_p    = prio_i[s];
        best_id_o = SRC_W'(s);
      end
    end
  end

  assign irq_o = (best_id_o != '0);

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_SRC = 53,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [31:0]        req_wdata_i,
  output logic [31:0]        rsp_rdata_o,
  output logic [NUM_CTX-1:0] irq_o
);

  localparam int SRC_W    = $clog2(NUM_SRC + 1);
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int EN_WORDS = (NUM_SRC + 32) / 32;
  localparam int EW_W     = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic rd_req, wr_req;
  assign rd_req = req_valid_i & ~req_write_i;
  assign wr_req = req_valid_i &  req_write_i;

  reg_kind_e        dec_kind;
  logic [SRC_W-1:0] dec_src;
  logic [CTX_W-1:0] dec_ctx;
  logic [EW_W-1:0]  dec_word;

  ext_irq_decode #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .EN_WORDS(EN_WORDS),
    .SRC_W(SRC_W), .CTX_W(CTX_W), .EW_W(EW_W)
  ) dec_i (
    .addr_i (req_addr_i),
    .kind_o (dec_kind),
    .src_o  (dec_src),
    .ctx_o  (dec_ctx),
    .word_o (dec_word)
  );

  logic [NUM_SRC:1][PRIO_W-1:0]              prio_q, prio_n;
  logic [NUM_CTX-1:0][NUM_SRC:1]             en_q, en_n;
  logic [NUM_CTX-1:0][PRIO_W-1:0]            thr_q, thr_n;
  logic [NUM_CTX-1:0][SRC_W-1:0]             best_id;
  logic [NUM_SRC:1]                          pend_vec, claim_vec, cmp_vec;
  logic [31:0]                               rd_n;

  // Configuration next state
  always_comb begin
    prio_n = prio_q;
    en_n   = en_q;
    thr_n  = thr_q;
    if (wr_req) begin
      case (dec_kind)
        RK_PRIO:   prio_n[dec_src] = req_wdata_i[PRIO_W-1:0];
        RK_ENABLE: begin
          for (int s = 1; s <= NUM_SRC; s++) begin
            if ((s / 32) == int'(dec_word)) en_n[dec_ctx][s] = req_wdata_i[s % 32];
          end
        end
        RK_THRESH: thr_n[dec_ctx] = req_wdata_i[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr_req) begin
      prio_q <= prio_n;
      en_q   <= en_n;
      thr_q  <= thr_n;
    end
  end

  // Read data mux
  always_comb begin
    rd_n = '0;
    case (dec_kind)
      RK_PRIO:   rd_n = 32'(prio_q[dec_src]);
      RK_ENABLE: begin
        for (int s = 1; s <= NUM_SRC; s++) begin
          if ((s / 32) == int'(dec_word)) rd_n[s % 32] = en_q[dec_ctx][s];
        end
      end
      RK_THRESH: rd_n = 32'(thr_q[dec_ctx]);
      RK_CLAIM:  rd_n = 32'(best_id[dec_ctx]);
      default:   rd_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_rdata_o <= '0;
    end else if (rd_req) begin
      rsp_rdata_o <= rd_n;
    end
  end

  // Claim and completion strobes per source
  always_comb begin
    for (int s = 1; s <= NUM_SRC; s++) begin
      claim_vec[s] = rd_req && (dec_kind == RK_CLAIM) && (best_id[dec_ctx] == SRC_W'(s));
      cmp_vec[s]   = wr_req && (dec_kind == RK_CLAIM) && (req_wdata_i == 32'(s));
    end
  end

  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_gw
    ext_irq_gateway gw_i (
      .clk        (clk),
      .rst_ni     (rst_sync_n),
      .level_i    (src_irq_i[g-1]),
      .claim_i    (claim_vec[g]),
      .complete_i (cmp_vec[g]),
      .pending_o  (pend_vec[g])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    ext_irq_target #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W)
    ) tgt_i (
      .pending_i (pend_vec),
      .enable_i  (en_q[c]),
      .prio_i    (prio_q),
      .thresh_i  (thr_q[c]),
      .best_id_o (best_id[c]),
      .irq_o     (irq_o[c])
    );
  end

  // R10: unmapped reads answer zero on the next cycle
  assert_unmapped_zero_R10: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    (rd_req && dec_kind == RK_NONE) |=> (rsp_rdata_o == 32'd0))
    else $error("unmapped read returned nonzero");

  // R5: a claim on a quiet context answers zero
  assert_claim_empty_R5: assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    (rd_req && dec_kind == RK_CLAIM && !irq_o[dec_ctx]) |=> (rsp_rdata_o == 32'd0))
    else $error("claim on idle context returned an ID");

endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;

  localparam int NSRC = 53;
  localparam int NCTX = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_irq = '0;
  logic            req_valid = 1'b0;
  logic            req_write = 1'b0;
  logic [23:0]     req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic [31:0]     rsp_rdata;
  logic [NCTX-1:0] irq;

  always #2 clk = ~clk;

  ext_irq_ctrl #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PRIO_W(3), .ADDR_W(24)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_irq_i(src_irq),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic mon_due = 1'b0;
  logic [31:0] mon_exp;
  string mon_tag;

  function automatic logic [31:0] prio_a(int s); return 32'(4 * s); endfunction
  function automatic logic [31:0] en_a(int c, int w); return 32'h2000 + 32'(128 * c) + 32'(4 * w); endfunction
  function automatic logic [31:0] thr_a(int c); return 32'h20_0000 + 32'(4096 * c); endfunction
  function automatic logic [31:0] clm_a(int c); return thr_a(c) + 32'd4; endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic check_irq(input string tag, input logic [NCTX-1:0] exp);
    check(tag, 32'(irq), 32'(exp));
  endtask

  task automatic bus_write(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = addr[23:0]; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // Driver: issue a read and hand the expected value to the scoreboard
  task automatic bus_read(input logic [31:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = addr[23:0];
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_level(input int s, input logic v);
    @(negedge clk);
    src_irq[s-1] = v;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compare read data the cycle after each read
  always @(posedge clk) mon_due <= req_valid && !req_write;

  always @(negedge clk) begin
    if (mon_due) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: actual=0x%08h expected=none", rsp_rdata);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        check(mon_tag, rsp_rdata, mon_exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R11 reset state
    check_irq("R11 irq after reset", 2'b00);
    bus_read(prio_a(5), 32'd0, "R11 prio reset");
    bus_read(thr_a(0), 32'd0, "R11 threshold reset");
    bus_read(en_a(0, 0), 32'd0, "R11 enable reset");
    bus_read(clm_a(0), 32'd0, "R11 claim empty");

    // Setup: priorities 10=3, 12=5, 20=5; enable 7,10,12,20 on context 0
    bus_write(prio_a(10), 32'd3);
    bus_write(prio_a(12), 32'd5);
    bus_write(prio_a(20), 32'd5);
    bus_write(en_a(0, 0), 32'h0010_1480);
    bus_read(en_a(0, 0), 32'h0010_1480, "R3 enable word0 ctx0");

    // R2: priority zero source never signals
    set_level(7, 1'b1);
    idle(1);
    check_irq("R2 zero priority no irq", 2'b00);
    bus_read(clm_a(0), 32'd0, "R2 zero priority not claimable");

    // R4: threshold equal blocks, lower passes
    bus_write(thr_a(0), 32'd3);
    set_level(10, 1'b1);
    check_irq("R4 prio equal threshold blocked", 2'b00);
    bus_read(clm_a(0), 32'd0, "R4 claim at equal threshold");
    bus_write(thr_a(0), 32'd2);
    check_irq("R4 prio above threshold", 2'b01);

    // R5: highest priority, tie goes to lower ID
    set_level(20, 1'b1);
    set_level(12, 1'b1);
    bus_read(clm_a(0), 32'd12, "R5 tie lower ID first");
    bus_read(clm_a(0), 32'd20, "R5 second of tie");
    check_irq("R6 irq held by remaining source", 2'b01);
    bus_read(clm_a(0), 32'd10, "R5 lower priority last");
    check_irq("R6 irq drops after last claim", 2'b00);
    bus_read(clm_a(0), 32'd0, "R5 claim returns zero when empty");

    // R6: held levels do not re-request while in flight
    idle(3);
    check_irq("R6 held level blocked", 2'b00);

    // R8: bad completions ignored
    bus_write(clm_a(0), 32'd60);
    bus_write(clm_a(0), 32'd7);
    bus_write(clm_a(0), 32'd0);
    idle(2);
    check_irq("R8 bad completions ignored", 2'b00);
    bus_read(clm_a(0), 32'd0, "R8 no source unblocked");

    // R7: completion re-arms held level
    bus_write(clm_a(0), 32'd12);
    idle(1);
    check_irq("R7 re-arm after completion", 2'b01);
    bus_read(clm_a(0), 32'd12, "R7 re-armed source claimed");
    set_level(12, 1'b0);
    bus_write(clm_a(0), 32'd12);
    idle(2);
    check_irq("R7 no re-arm with level low", 2'b00);
    bus_read(clm_a(0), 32'd0, "R7 nothing pending");

    // R9: second context with its own enable and threshold
    bus_write(thr_a(1), 32'd1);
    bus_read(thr_a(1), 32'd1, "R9 threshold ctx1 readback");
    bus_write(en_a(1, 0), 32'h0010_0000);
    check_irq("R9 in-flight source silent on ctx1", 2'b00);
    bus_write(clm_a(1), 32'd20);
    idle(1);
    check_irq("R9 both contexts see source 20", 2'b11);
    bus_read(clm_a(1), 32'd20, "R9 claim through ctx1");
    check_irq("R9 claim clears for both", 2'b00);
    bus_write(clm_a(0), 32'd10);
    idle(1);
    check_irq("R9 source 10 only on ctx0", 2'b01);
    bus_read(clm_a(1), 32'd0, "R9 ctx1 does not see source 10");
    bus_read(clm_a(0), 32'd10, "R9 ctx0 claims source 10");
    check_irq("R9 all quiet", 2'b00);

    // R10: unmapped and misaligned reads
    bus_read(32'h0000_1000, 32'd0, "R10 gap region");
    bus_read(32'h0020_0008, 32'd0, "R10 past claim register");
    bus_read(thr_a(2), 32'd0, "R10 context out of range");
    bus_read(en_a(0, 2), 32'd0, "R10 enable word out of range");
    bus_read(prio_a(54), 32'd0, "R10 past last priority");
    bus_read(prio_a(10) + 32'd1, 32'd0, "R10 misaligned");

    // R1: priority width, reserved slot, last source
    bus_write(prio_a(30), 32'hFFFF_FFFF);
    bus_read(prio_a(30), 32'd7, "R1 priority truncated");
    bus_write(prio_a(0), 32'd3);
    bus_read(prio_a(0), 32'd0, "R1 source 0 reserved");
    bus_write(prio_a(53), 32'd4);
    bus_read(prio_a(53), 32'd4, "R1 last source priority");

    // R3: enable padding bits
    bus_write(en_a(1, 1), 32'hFFFF_FFFF);
    bus_read(en_a(1, 1), 32'h003F_FFFF, "R3 enable word1 padding");
    bus_write(en_a(1, 0), 32'hFFFF_FFFF);
    bus_read(en_a(1, 0), 32'hFFFF_FFFE, "R3 enable bit 0 reserved");
    bus_read(en_a(0, 0), 32'h0010_1480, "R3 ctx0 untouched by ctx1");

    idle(3);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule